// File: doc/BRIEF.md
# SDLC Loop Repeater Controller

This block manages a secondary station on an SDLC loop. It chooses what drives the outgoing serial line from three sources: the incoming line wired straight through, the incoming line delayed by one bit period, or the station's own transmitter. A receive-side pattern window watches the incoming bits for flags and for the end-of-poll sequence. The station takes control of the loop only when software has set the poll-response control bit and an end-of-poll sequence then arrives. It gives the loop back at a flag boundary.

When loop operation is first enabled, the station is a plain wire. The first end-of-poll seen with the poll bit set puts the station on the loop, which inserts the one-bit delay. A later end-of-poll, still with the poll bit set, makes the transmitter active. Each time the transmitter reports that a flag has left its shifter, the block either keeps the loop or releases it. To keep the loop it may ask for a data byte. To release it, it drops back to one-bit-delay repeating. After a release the station must see a flag and then a new end-of-poll before it may send again.

Top module: `sdlc_loop_repeater`

## Requirements
- R1: After reset, with loop operation enabled, on_loop_o and tx_active_o are 0 and tx_o follows rx_i combinationally, with no register in the path.
- R2: While loop_en_i is 0, tx_o equals tx_ser_i and both status outputs read 0 from the next clock edge.
- R3: In pass-through mode, an end-of-poll is ignored while poll_go_i is 0. An end-of-poll is eight received bits, oldest first, equal to 0 then seven 1s; a bit is received on each edge where bit_en_i is 1.
- R4: In pass-through mode, an end-of-poll completing on a bit-enable edge while poll_go_i is 1 sets on_loop_o at that edge.
- R5: On the loop and not transmitting, tx_o equals the rx_i value sampled at the most recent bit-enable edge, and it holds between bit enables.
- R6: On the loop, a qualifying end-of-poll received while poll_go_i is 1 sets tx_active_o at that edge, and tx_o then equals tx_ser_i. An end-of-poll qualifies if it is the first one after going on the loop, or the first one after a flag (0, six 1s, 0, oldest first).
- R7: While active, when tx_flag_done_i is 1 and poll_go_i is 1, the station stays active, and load_data_o equals tx_data_avail_i in that same cycle.
- R8: While active, tx_flag_done_i with poll_go_i at 0 clears tx_active_o at that edge and leaves on_loop_o at 1.
- R9: After releasing the loop, an end-of-poll that has no flag received after the release does not make the station active. A flag followed by an end-of-poll does.
- R10: On the loop, an end-of-poll received while poll_go_i is 0 does not make the station active, and it does not cancel a flag that was received earlier.
- R11: A flag that completes on the same edge at which the station releases the loop does not count toward a later reactivation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_en_i | input | 1 | Bit-period clock enable |
| rx_i | input | 1 | Receive serial line |
| loop_en_i | input | 1 | Loop operation enable |
| poll_go_i | input | 1 | Software poll-response control bit |
| tx_flag_done_i | input | 1 | Strobe: a flag is leaving the transmit shifter |
| tx_data_avail_i | input | 1 | Transmitter has a data byte waiting |
| tx_ser_i | input | 1 | Serial output of the station transmitter |
| tx_o | output | 1 | Transmit serial line |
| on_loop_o | output | 1 | Station has inserted the one-bit delay |
| tx_active_o | output | 1 | Station transmitter holds the loop |
| load_data_o | output | 1 | Request for the transmitter to send a data byte next |

## Verification
Two events can land on the same edge: the transmitter's flag-leaving strobe, and the completion of a received flag on the bit window. The bench creates this case by pulsing tx_flag_done_i with poll_go_i low on the bit-enable edge that carries the last 0 of a received flag. The release is judged correct if a following end-of-poll leaves the station on the loop but inactive. Only after a fresh flag and end-of-poll may it become active again.

// File: rtl/sdlc_loop_pkg.sv
package sdlc_loop_pkg;
  typedef enum logic [1:0] {
    LP_PASS   = 2'd0,
    LP_DELAY  = 2'd1,
    LP_ACTIVE = 2'd2
  } lp_mode_e;

  localparam int unsigned PAT_W    = 8;
  localparam logic [PAT_W-1:0] FLAG_PAT = 8'b0111_1110;
  localparam logic [PAT_W-1:0] EOP_PAT  = 8'b0111_1111;
endpackage

// File: rtl/sdlc_rx_window.sv
module sdlc_rx_window #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bit_en_i,
  input  logic         rx_i,
  output logic [W-1:0] win_nxt_o
);
  logic [W-1:0] sh_q;

  // window including the bit being sampled now; oldest bit in MSB
  assign win_nxt_o = {sh_q[W-2:0], rx_i};

  // reset to all ones so no pattern with a leading 0 matches early
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sh_q <= '1;
    else if (bit_en_i) sh_q <= win_nxt_o;
  end
endmodule

// File: rtl/sdlc_bit_delay.sv
module sdlc_bit_delay #(
  parameter int unsigned DEPTH = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_en_i,
  input  logic d_i,
  output logic q_o
);
  generate
    if (DEPTH == 1) begin : g_single
      logic q_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       q_q <= 1'b1;
        else if (bit_en_i) q_q <= d_i;
      end
      assign q_o = q_q;
    end else begin : g_chain
      logic [DEPTH-1:0] q_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       q_q <= '1;
        else if (bit_en_i) q_q <= {q_q[DEPTH-2:0], d_i};
      end
      assign q_o = q_q[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/sdlc_loop_fsm.sv
module sdlc_loop_fsm
  import sdlc_loop_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     loop_en_i,
  input  logic     poll_go_i,
  input  logic     flag_hit_i,
  input  logic     eop_hit_i,
  input  logic     tx_flag_done_i,
  output lp_mode_e mode_o
);
  lp_mode_e mode_q, mode_d;
  logic     armed_q, armed_d;

  always_comb begin
    mode_d  = mode_q;
    armed_d = armed_q;
    if (!loop_en_i) begin
      mode_d  = LP_PASS;
      armed_d = 1'b0;
    end else begin
      unique case (mode_q)
        LP_PASS: begin
          if (eop_hit_i && poll_go_i) begin
            mode_d  = LP_DELAY;
            armed_d = 1'b1;
          end
        end
        LP_DELAY: begin
          if (flag_hit_i) armed_d = 1'b1;
          if (eop_hit_i && poll_go_i && armed_q) begin
            mode_d  = LP_ACTIVE;
            armed_d = 1'b0;
          end
        end
        LP_ACTIVE: begin
          // flags heard while sending never arm
          if (tx_flag_done_i && !poll_go_i) begin
            mode_d  = LP_DELAY;
            armed_d = 1'b0;
          end
        end
        default: begin
          mode_d  = LP_PASS;
          armed_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= LP_PASS;
      armed_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      armed_q <= armed_d;
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/sdlc_loop_repeater.sv
module sdlc_loop_repeater
  import sdlc_loop_pkg::*;
#(
  parameter int unsigned DELAY_BITS = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_en_i,
  input  logic rx_i,
  input  logic loop_en_i,
  input  logic poll_go_i,
  input  logic tx_flag_done_i,
  input  logic tx_data_avail_i,
  input  logic tx_ser_i,
  output logic tx_o,
  output logic on_loop_o,
  output logic tx_active_o,
  output logic load_data_o
);
  localparam int unsigned NPAT = 2;
  localparam logic [NPAT*PAT_W-1:0] PATS = {EOP_PAT, FLAG_PAT};

  logic [PAT_W-1:0] win_nxt;
  logic [NPAT-1:0]  hit;
  logic             dly_bit;
  lp_mode_e         mode;

  sdlc_rx_window #(.W(PAT_W)) u_win (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_en_i  (bit_en_i),
    .rx_i      (rx_i),
    .win_nxt_o (win_nxt)
  );

  generate
    for (genvar k = 0; k < NPAT; k++) begin : g_match
      assign hit[k] = bit_en_i && (win_nxt == PATS[k*PAT_W +: PAT_W]);
    end
  endgenerate

  sdlc_bit_delay #(.DEPTH(DELAY_BITS)) u_dly (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bit_en_i (bit_en_i),
    .d_i      (rx_i),
    .q_o      (dly_bit)
  );

  sdlc_loop_fsm u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .loop_en_i      (loop_en_i),
    .poll_go_i      (poll_go_i),
    .flag_hit_i     (hit[0]),
    .eop_hit_i      (hit[1]),
    .tx_flag_done_i (tx_flag_done_i),
    .mode_o         (mode)
  );

  always_comb begin
    if (!loop_en_i) tx_o = tx_ser_i;
    else begin
      unique case (mode)
        LP_DELAY:  tx_o = dly_bit;
        LP_ACTIVE: tx_o = tx_ser_i;
        default:   tx_o = rx_i;
      endcase
    end
  end

  assign on_loop_o   = (mode == LP_DELAY) || (mode == LP_ACTIVE);
  assign tx_active_o = (mode == LP_ACTIVE);
  assign load_data_o = tx_active_o && tx_flag_done_i && poll_go_i && tx_data_avail_i;
endmodule

// File: rtl/sdlc_loop_repeater_chk.sv
module sdlc_loop_repeater_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bit_en_i,
  input logic rx_i,
  input logic loop_en_i,
  input logic poll_go_i,
  input logic tx_flag_done_i,
  input logic tx_data_avail_i,
  input logic tx_ser_i,
  input logic tx_o,
  input logic on_loop_o,
  input logic tx_active_o,
  input logic load_data_o
);
  p_active_on_loop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_active_o |-> on_loop_o);

  p_go_active_poll_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_active_o) |-> ($past(poll_go_i) && $past(bit_en_i)));

  p_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loop_en_i && tx_active_o && tx_flag_done_i && !poll_go_i) |=> (!tx_active_o && on_loop_o));

  p_load_only_active_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_data_o |-> (tx_active_o && tx_data_avail_i));

  p_off_loop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !loop_en_i |=> (!on_loop_o && !tx_active_o));

  p_one_bit_delay_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loop_en_i && on_loop_o && !tx_active_o && $past(on_loop_o) && $past(bit_en_i))
      |-> (tx_o == $past(rx_i)));

  p_pass_wire_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loop_en_i && !on_loop_o) |-> (tx_o == rx_i));
endmodule

bind sdlc_loop_repeater sdlc_loop_repeater_chk u_chk (.*);

// File: tb/tb_sdlc_loop_repeater.sv
module tb_sdlc_loop_repeater;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic bit_en = 1'b0, rx = 1'b1, loop_en = 1'b0, poll = 1'b0;
  logic fdone = 1'b0, avail = 1'b0, tx_ser = 1'b0;
  logic tx, on_loop, active, load;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  sdlc_loop_repeater dut (
    .clk_i(clk), .rst_ni(rst_ni), .bit_en_i(bit_en), .rx_i(rx),
    .loop_en_i(loop_en), .poll_go_i(poll), .tx_flag_done_i(fdone),
    .tx_data_avail_i(avail), .tx_ser_i(tx_ser), .tx_o(tx),
    .on_loop_o(on_loop), .tx_active_o(active), .load_data_o(load)
  );

  localparam logic [2:0] OP_LOOP = 3'd0, OP_POLL = 3'd1, OP_BYTE = 3'd2, OP_FDN = 3'd3;
  // {op, arg, exp_on_loop, exp_active}; OP_FDN arg[0]=avail, arg[1]=exp load
  localparam int NV = 16;
  localparam logic [12:0] VEC [NV] = '{
    {OP_LOOP, 8'h01, 1'b0, 1'b0},
    {OP_BYTE, 8'h00, 1'b0, 1'b0},
    {OP_BYTE, 8'h7F, 1'b0, 1'b0},  // R3 eop, poll clear
    {OP_POLL, 8'h01, 1'b0, 1'b0},
    {OP_BYTE, 8'h7F, 1'b1, 1'b0},  // R4
    {OP_BYTE, 8'h7F, 1'b1, 1'b1},  // R6
    {OP_FDN,  8'h03, 1'b1, 1'b1},  // R7 load
    {OP_FDN,  8'h00, 1'b1, 1'b1},  // R7 no data
    {OP_POLL, 8'h00, 1'b1, 1'b1},
    {OP_FDN,  8'h00, 1'b1, 1'b0},  // R8
    {OP_POLL, 8'h01, 1'b1, 1'b0},
    {OP_BYTE, 8'h7F, 1'b1, 1'b0},  // R9 no flag yet
    {OP_BYTE, 8'h7E, 1'b1, 1'b0},
    {OP_BYTE, 8'h7F, 1'b1, 1'b1},  // R9 flag then eop
    {OP_POLL, 8'h00, 1'b1, 1'b1},
    {OP_FDN,  8'h00, 1'b1, 1'b0}
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input logic pulse_fd);
    @(negedge clk);
    rx = b; bit_en = 1'b1; fdone = pulse_fd;
    @(negedge clk);
    bit_en = 1'b0; fdone = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i], 1'b0);
  endtask

  task automatic flag_done(input logic av, input logic exp_ld);
    @(negedge clk);
    avail = av; fdone = 1'b1;
    #5 check("R7 load_data", load, exp_ld);
    @(negedge clk);
    fdone = 1'b0; avail = 1'b0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  always @(negedge clk) tx_ser = ~tx_ser;

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state and combinational pass-through
    loop_en = 1'b1;
    check("R1 on_loop", on_loop, 1'b0);
    check("R1 active", active, 1'b0);
    rx = 1'b0; #1 check("R1 wire", tx, 1'b0);
    rx = 1'b1; #1 check("R1 wire", tx, 1'b1);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      case (VEC[v][12:10])
        OP_LOOP: begin @(negedge clk); loop_en = VEC[v][2]; @(negedge clk); end
        OP_POLL: begin @(negedge clk); poll = VEC[v][2]; end
        OP_BYTE: send_byte(VEC[v][9:2]);
        default: flag_done(VEC[v][2], VEC[v][3]);
      endcase
      check($sformatf("R4/R6/R8/R9 on_loop step %0d", v), on_loop, VEC[v][1]);
      check($sformatf("R6/R8/R9 active step %0d", v), active, VEC[v][0]);
      if (VEC[v][0]) begin
        #1 check("R6 tx follows transmitter", tx, tx_ser);
      end
    end

    // R10: eop with poll clear ignored, earlier flag kept
    send_byte(8'h7E);
    send_byte(8'h7F);
    check("R10 active", active, 1'b0);
    poll = 1'b1;
    send_byte(8'h7F);
    check("R10 kept arm", active, 1'b1);

    // R5: one-bit delay while on the loop
    poll = 1'b0;
    flag_done(1'b0, 1'b0);
    check("R5 on_loop", on_loop, 1'b1);
    send_bit(1'b0, 1'b0);
    rx = 1'b1; #1 check("R5 delayed bit", tx, 1'b0);
    send_bit(1'b1, 1'b0);
    rx = 1'b0; #1 check("R5 delayed bit", tx, 1'b1);

    // R11: release on the same edge as a received flag completes
    poll = 1'b1;
    send_byte(8'h7E);
    send_byte(8'h7F);
    check("R11 active before", active, 1'b1);
    poll = 1'b0;
    for (int i = 7; i >= 1; i--) send_bit(8'h7E >> i, 1'b0);
    send_bit(1'b0, 1'b1);
    check("R11 released", active, 1'b0);
    poll = 1'b1;
    send_byte(8'h7F);
    check("R11 not armed", active, 1'b0);
    send_byte(8'h7E);
    send_byte(8'h7F);
    check("R11 rearmed", active, 1'b1);

    // R2: loop disabled
    @(negedge clk); loop_en = 1'b0;
    #1 check("R2 tx", tx, tx_ser);
    @(negedge clk);
    check("R2 on_loop", on_loop, 1'b0);
    check("R2 active", active, 1'b0);
    #1 check("R2 tx", tx, tx_ser);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule